// File: doc/BRIEF.md
# Egress Time-Aware Gate Scheduler

This block produces the gate mask for the eight traffic-class queues of one egress port. Each bit of the mask marks one class as allowed to transmit (1) or held (0). The queue arbiter reads the mask directly. Software writes a list of up to 16 entries through a small register write port. Each entry pairs an 8-bit mask with a duration in nanoseconds. Software also writes a cycle length, an absolute start time and a commit word.

From the start time on, the block steps through the list against a synchronized 64-bit nanosecond time input, and it restarts the list at every cycle boundary. All gate events lie on a 200 ns slot grid anchored at the start time.

The block shares its timing engine with one other schedule. Software describes that schedule by writing the slot offsets at which its events fall. A new list whose own events land in one of those slots is refused. A list committed while the block runs replaces the active one exactly at the next cycle boundary.

Top module: `egress_gate_sched`

## Requirements
- R1: After reset, `gate_mask` is 8'hFF and both error flags are 0.
- R2: After an enabling commit, `gate_mask` stays 8'hFF while `now_ns` is below the start time. In the first clock in which `now_ns` is at or beyond the start time, it shows the mask of entry 0.
- R3: Entry i becomes active in the first clock in which `now_ns` reaches start + 200 ns × (sum of the slot counts of entries 0..i-1). Entries follow in index order up to the last index, which is written at address 0x24, bits [3:0].
- R4: The list restarts at entry 0 at every cycle boundary. A cycle lasts 200 ns × the slot count written at address 0x23, bits [23:0]. The last entry holds until the boundary. An entry that would start at or after the boundary never becomes active.
- R5: An entry is written at addresses 0x00–0x0F, with the mask in bits [7:0] and the duration in ns in bits [31:8]. The duration is stored as floor((ns + 100) / 200) slots.
- R6: An entry write whose duration rounds to 0 slots (ns < 100) changes neither the mask nor the duration of that entry, and it sets `err_zero`.
- R7: When an enabling commit finds the start time (addresses 0x21 low word, 0x22 high word) below `now_ns`, the start is moved to the smallest value start + k × cycle that is not below `now_ns`.
- R8: Peer event offsets, in slots, are written at 0x10–0x1F, and the number of peer offsets in use at 0x20. If any own event offset below the cycle length equals a peer offset, the commit sets `err_clash` and the new list is not applied. Own event offsets are 0 and each cumulative sum.
- R9: A list committed while the schedule is running takes effect at the next cycle boundary. The old list stays active until that boundary.
- R10: A commit word (address 0x25) with bit 0 = 0 disables the block, and `gate_mask` is 8'hFF from the next clock.
- R11: Every write to address 0x25 clears `err_zero` and `err_clash`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register address |
| wr_data | input | 32 | Register write data |
| now_ns | input | 64 | Synchronized time in nanoseconds |
| gate_mask | output | 8 | Open/closed bit per traffic class |
| err_zero | output | 1 | An entry write was refused for a zero-slot duration |
| err_clash | output | 1 | The last commit was refused for a slot clash with the peer |

## Verification
The bench builds the block with its default parameters: 16 entries, a 200 ns slot and a 24-bit cycle field. It runs short lists of two and four entries with cycles of 2500, 20 and 4 slots. With the 20-slot and 4-slot cycles, a 100 ns sweep of the time input visits both sides of every slot edge over several full cycles, and the expected mask is computed from the bench's own model of the slot arithmetic. The time input is driven directly by the bench, so it can start a schedule whose base lies in the past, place the peer offset on and off an event slot, and commit a list in the middle of a cycle to observe the swap at the boundary.

// File: rtl/egress_gate_sched.sv
`timescale 1ns/1ps
module egress_gate_sched #(
  parameter int N_ENT   = 16,
  parameter int SLOT_NS = 200,
  parameter int CYC_W   = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [5:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [63:0] now_ns,
  output logic [7:0]  gate_mask,
  output logic        err_zero,
  output logic        err_clash
);
  localparam int TIME_W = 64;
  localparam int IDX_W  = $clog2(N_ENT);
  localparam int PCNT_W = IDX_W + 1;
  localparam int NS_W   = 24;
  localparam int SLOT_W = $clog2(((1 << NS_W) + SLOT_NS/2) / SLOT_NS + 1);
  localparam int ACC_W  = ((SLOT_W + IDX_W > CYC_W) ? SLOT_W + IDX_W : CYC_W) + 1;

  typedef enum logic [1:0] {S_IDLE, S_ALIGN, S_WAIT, S_RUN} st_t;

  st_t               st;
  logic [7:0]        p_mask [N_ENT];
  logic [7:0]        a_mask [N_ENT];
  logic [SLOT_W-1:0] p_slots[N_ENT];
  logic [SLOT_W-1:0] a_slots[N_ENT];
  logic [CYC_W-1:0]  peer_off[N_ENT];
  logic [CYC_W-1:0]  p_cyc, a_cyc;
  logic [IDX_W-1:0]  p_last, a_last, idx, chk_idx;
  logic [PCNT_W-1:0] peer_cnt;
  logic [TIME_W-1:0] base, start, next_evt, cyc_end;
  logic [ACC_W-1:0]  chk_acc;
  logic              chk_busy, pend_ok, hit, running;

  function automatic logic [TIME_W-1:0] ns_of(input logic [ACC_W-1:0] s);
    return TIME_W'(s) * TIME_W'(SLOT_NS);
  endfunction

  wire [IDX_W-1:0] wa     = wr_addr[IDX_W-1:0];
  wire             in_rng = int'(wr_addr[3:0]) < N_ENT;
  wire             ent_we = wr_en && wr_addr[5:4] == 2'b00 && in_rng;
  wire             peer_we = wr_en && wr_addr[5:4] == 2'b01 && in_rng;
  wire [NS_W:0]    ns_r   = {1'b0, wr_data[31:8]} + (NS_W+1)'(SLOT_NS/2);
  wire [NS_W:0]    slot_q = ns_r / (NS_W+1)'(SLOT_NS);

  wire [SLOT_W-1:0] nb_s0  = pend_ok ? p_slots[0] : a_slots[0];
  wire [CYC_W-1:0]  nb_cyc = pend_ok ? p_cyc : a_cyc;

  assign running   = st == S_RUN;
  assign gate_mask = running ? a_mask[idx] : 8'hFF;

  always_comb begin
    hit = 1'b0;
    for (int j = 0; j < N_ENT; j++)
      if (j < int'(peer_cnt) && ACC_W'(peer_off[j]) == chk_acc && chk_acc < ACC_W'(p_cyc))
        hit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      chk_busy <= 1'b0;
      pend_ok <= 1'b0;
      err_zero <= 1'b0;
      err_clash <= 1'b0;
      idx <= '0;
      chk_idx <= '0;
      chk_acc <= '0;
      p_cyc <= '0;
      a_cyc <= '0;
      p_last <= '0;
      a_last <= '0;
      peer_cnt <= '0;
      base <= '0;
      start <= '0;
      next_evt <= '0;
      cyc_end <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        p_mask[i] <= 8'hFF;
        a_mask[i] <= 8'hFF;
        p_slots[i] <= SLOT_W'(1);
        a_slots[i] <= SLOT_W'(1);
        peer_off[i] <= '0;
      end
    end else begin
      case (st)
        S_ALIGN:
          if (start < now_ns) start <= start + ns_of(ACC_W'(a_cyc));
          else st <= S_WAIT;
        S_WAIT:
          if (now_ns >= start) begin
            st <= S_RUN;
            idx <= '0;
            next_evt <= start + ns_of(ACC_W'(a_slots[0]));
            cyc_end <= start + ns_of(ACC_W'(a_cyc));
          end
        S_RUN:
          if (now_ns >= cyc_end) begin
            if (pend_ok) begin
              for (int i = 0; i < N_ENT; i++) begin
                a_mask[i] <= p_mask[i];
                a_slots[i] <= p_slots[i];
              end
              a_cyc <= p_cyc;
              a_last <= p_last;
              pend_ok <= 1'b0;
            end
            idx <= '0;
            next_evt <= cyc_end + ns_of(ACC_W'(nb_s0));
            cyc_end <= cyc_end + ns_of(ACC_W'(nb_cyc));
          end else if (now_ns >= next_evt && idx != a_last) begin
            idx <= idx + 1'b1;
            next_evt <= next_evt + ns_of(ACC_W'(a_slots[idx + 1'b1]));
          end
        default: ;
      endcase

      if (chk_busy) begin
        if (hit) begin
          err_clash <= 1'b1;
          chk_busy <= 1'b0;
        end else if (chk_idx == p_last) begin
          chk_busy <= 1'b0;
          if (running) pend_ok <= 1'b1;
          else begin
            for (int i = 0; i < N_ENT; i++) begin
              a_mask[i] <= p_mask[i];
              a_slots[i] <= p_slots[i];
            end
            a_cyc <= p_cyc;
            a_last <= p_last;
            start <= base;
            st <= S_ALIGN;
          end
        end else begin
          chk_acc <= chk_acc + ACC_W'(p_slots[chk_idx]);
          chk_idx <= chk_idx + 1'b1;
        end
      end

      if (ent_we) begin
        if (slot_q == '0) err_zero <= 1'b1;
        else begin
          p_mask[wa] <= wr_data[7:0];
          p_slots[wa] <= slot_q[SLOT_W-1:0];
        end
      end
      if (peer_we) peer_off[wa] <= wr_data[CYC_W-1:0];
      if (wr_en) begin
        case (wr_addr)
          6'h20: peer_cnt <= wr_data[PCNT_W-1:0];
          6'h21: base[31:0] <= wr_data;
          6'h22: base[63:32] <= wr_data;
          6'h23: p_cyc <= wr_data[CYC_W-1:0];
          6'h24: p_last <= wr_data[IDX_W-1:0];
          6'h25: begin
            err_zero <= 1'b0;
            err_clash <= 1'b0;
            pend_ok <= 1'b0;
            chk_idx <= '0;
            chk_acc <= '0;
            chk_busy <= wr_data[0];
            if (!wr_data[0]) st <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module egress_gate_sched_chk #(
  parameter int IDX_W   = 4,
  parameter int SLOT_NS = 200
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [5:0]       wr_addr,
  input logic             ctl_en,
  input logic [23:0]      ent_ns,
  input logic [7:0]       gate_mask,
  input logic             err_zero,
  input logic             err_clash,
  input logic             running,
  input logic [IDX_W-1:0] idx,
  input logic [IDX_W-1:0] a_last
);
  // R10
  disable_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 6'h25 && !ctl_en) |=> gate_mask == 8'hFF);

  // R6
  zero_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[5:4] == 2'b00 && int'(ent_ns) < SLOT_NS/2) |=> err_zero);

  // R11
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 6'h25) |=> (!err_zero && !err_clash));

  // R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> idx <= a_last);

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |->
      (idx == $past(idx) || idx == $past(idx) + 1'b1 || idx == '0));
endmodule

bind egress_gate_sched egress_gate_sched_chk #(.IDX_W(IDX_W), .SLOT_NS(SLOT_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .ctl_en(wr_data[0]), .ent_ns(wr_data[31:8]),
  .gate_mask(gate_mask), .err_zero(err_zero), .err_clash(err_clash),
  .running(running), .idx(idx), .a_last(a_last)
);

// File: tb/test_egress_gate_sched.sv
`timescale 1ns/1ps
module test_egress_gate_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] now_ns = 64'd1000;
  logic [7:0]  gate_mask;
  logic        err_zero, err_clash;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] m_mask [16];
  longint     m_slots[16];
  longint     m_last, m_cyc, m_base;
  bit         m_on = 0;

  always #2.5 clk = ~clk;

  egress_gate_sched i_egress_gate_sched (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .now_ns(now_ns), .gate_mask(gate_mask), .err_zero(err_zero), .err_clash(err_clash)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put(input int i, input logic [7:0] mask, input int ns);
    wr(6'(i), {ns[23:0], mask});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_at(input longint t);
    longint cyc_ns, off, acc;
    logic [7:0] m;
    if (!m_on || t < m_base) return 8'hFF;
    cyc_ns = m_cyc * 200;
    off = (t - m_base) % cyc_ns;
    acc = 0;
    m = m_mask[0];
    for (int i = 0; i <= m_last; i++) begin
      if (acc < m_cyc && off >= acc * 200) m = m_mask[i];
      acc += m_slots[i];
    end
    return m;
  endfunction

  task automatic step_to(input longint t, input string tag);
    @(negedge clk);
    now_ns = 64'(t);
    @(posedge clk);
    #1;
    chk(tag, {24'd0, gate_mask}, {24'd0, exp_at(t)});
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mask", {24'd0, gate_mask}, 32'hFF);
    chk("R1 errors", {30'd0, err_zero, err_clash}, 32'd0);

    // Reference list: class 7 for 100 us, classes 0-6 for 400 us, 500 us cycle
    put(0, 8'h80, 100000);
    put(1, 8'h7F, 400000);
    wr(6'h24, 32'd1);
    wr(6'h23, 32'd2500);
    wr(6'h21, 32'd10000);
    wr(6'h22, 32'd0);
    wr(6'h20, 32'd0);
    wr(6'h25, 32'd1);
    idle(40);
    m_mask[0] = 8'h80; m_slots[0] = 500;
    m_mask[1] = 8'h7F; m_slots[1] = 2000;
    m_last = 1; m_cyc = 2500; m_base = 10000; m_on = 1;
    step_to(2000, "R2 before start");
    step_to(9999, "R2 one ns before start");
    step_to(10000, "R2 at start");
    for (longint t = 12500; t <= 10000 + 3 * 500000; t += 2500)
      step_to(t, (t < 510000) ? "R3 reference cycle" : "R4 repeat");

    // Four entries, rounding, hold, zero-duration refusal
    wr(6'h25, 32'd0);
    chk("R10 disable", {24'd0, gate_mask}, 32'hFF);
    m_on = 0;
    put(0, 8'h01, 299);
    put(1, 8'h02, 300);
    put(2, 8'h04, 500);
    put(3, 8'h08, 1099);
    put(0, 8'hAA, 99);
    chk("R6 err_zero set", {31'd0, err_zero}, 32'd1);
    wr(6'h24, 32'd3);
    wr(6'h23, 32'd20);
    wr(6'h21, 32'd2000000);
    wr(6'h25, 32'd1);
    chk("R11 err_zero cleared", {31'd0, err_zero}, 32'd0);
    idle(40);
    m_mask[0] = 8'h01; m_slots[0] = (299 + 100) / 200;
    m_mask[1] = 8'h02; m_slots[1] = (300 + 100) / 200;
    m_mask[2] = 8'h04; m_slots[2] = (500 + 100) / 200;
    m_mask[3] = 8'h08; m_slots[3] = (1099 + 100) / 200;
    m_last = 3; m_cyc = 20; m_base = 2000000; m_on = 1;
    for (longint t = 1999900; t <= 2012000; t += 100)
      step_to(t, (t < 2004000) ? "R5 rounded slots and R6 entry kept" : "R4 last entry holds");

    // Short cycle truncates the list
    wr(6'h25, 32'd0);
    m_on = 0;
    wr(6'h23, 32'd4);
    wr(6'h21, 32'd2100000);
    wr(6'h25, 32'd1);
    idle(40);
    m_cyc = 4; m_base = 2100000; m_on = 1;
    for (longint t = 2099900; t <= 2102400; t += 100)
      step_to(t, "R4 truncated cycle");

    // Start time in the past
    wr(6'h25, 32'd0);
    m_on = 0;
    wr(6'h23, 32'd20);
    @(negedge clk);
    now_ns = 64'd2200000;
    wr(6'h21, 32'd2191000);
    wr(6'h25, 32'd1);
    idle(40);
    m_cyc = 20;
    m_base = 2191000 + ((2200000 - 2191000 + 4000 - 1) / 4000) * 4000;
    m_on = 1;
    step_to(m_base - 100, "R7 moved start not reached");
    for (longint t = m_base; t <= m_base + 4000; t += 100)
      step_to(t, "R7 moved start");

    // Clash with the peer schedule refuses the list
    put(0, 8'h10, 299);
    put(1, 8'h20, 300);
    put(2, 8'h40, 500);
    put(3, 8'h80, 1099);
    wr(6'h10, 32'd3);
    wr(6'h20, 32'd1);
    wr(6'h25, 32'd1);
    idle(40);
    chk("R8 err_clash set", {31'd0, err_clash}, 32'd1);
    for (longint t = m_base + 4100; t <= m_base + 8000; t += 100)
      step_to(t, "R8 old list kept");

    // No clash: swap at the next boundary
    wr(6'h10, 32'd4);
    wr(6'h25, 32'd1);
    idle(40);
    chk("R8 no clash", {31'd0, err_clash}, 32'd0);
    for (longint t = m_base + 8100; t <= m_base + 11900; t += 100)
      step_to(t, "R9 old list before boundary");
    m_mask[0] = 8'h10; m_mask[1] = 8'h20; m_mask[2] = 8'h40; m_mask[3] = 8'h80;
    for (longint t = m_base + 12000; t <= m_base + 16000; t += 100)
      step_to(t, "R9 new list after boundary");

    wr(6'h25, 32'd0);
    chk("R10 disable while running", {24'd0, gate_mask}, 32'hFF);

    summary();
    $finish;
  end
endmodule